// File: doc/BRIEF.md
# Multi-Port Interrupt Aggregator

This block gathers single-cycle event pulses from eight identical ports and folds them into one active-low interrupt pin. Each port holds six latched status words: two for its transmit framer, two for its receive framer, one for its line interface and one for its bit-error tester. Every status word has its own enable word, in which a 1 lets the matching status bit raise the interrupt. An event always latches its status bit, whatever the enable setting. The enable only decides whether the bit is passed upward.

Above the status words, each port shows two live summary words. One has a bit per transmit status word and the other a bit per receive status word. Each bit is set while that word has a latched bit that is also enabled. Three global summary words sit above the ports, each with one bit per port. The framer word covers transmit and receive sources, the line word covers the line-interface status, and the tester word covers the tester status. Software reaches everything through a synchronous register port with combinational read data. It finds the pending port from the global words. It then reads that port's summary words, or goes straight to the line or tester status word, and clears serviced bits by writing 1 to them.

Top module: `irq_aggregator`

## Requirements
- R1: After reset is released, every status word and every enable word reads 0, and `irq_n_o` is 1.
- R2: A pulse on `evt_i` bit ((p*6+r)*8+b) sets bit b of status word r of port p at the next clock edge, whether that bit is enabled or not. Word r is 0,1 for transmit, 2,3 for receive, 4 for line and 5 for tester.
- R3: A write to a status word clears each bit where `wdata_i` is 1 and leaves each bit where it is 0 unchanged.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: An enable bit of 0 keeps its status bit out of every summary level and out of the interrupt. The address map within port p is offset 0..5 for status word r, offset 8+r for its enable word, offset 6 for the transmit summary and offset 7 for the receive summary, all at address p*16 + offset.
- R6: Bit k (k=0,1) of the transmit summary is 1 exactly when status word k has a bit that is set and enabled. Bit k of the receive summary does the same for status word 2+k.
- R7: Bit p of the global framer word (0xF0) is the OR of port p's two summaries. Bit p of the global line word (0xF1) is set when port p's word 4 has a bit that is set and enabled. The global tester word (0xF2) does the same for word 5.
- R8: The summary and global words are live. A read in the cycle after a clear or a disable already shows the bit gone.
- R9: Writes to the summary words and the global words change nothing.
- R10: `irq_n_o` goes low at the first clock edge after any global bit becomes 1. It returns high at the first edge after all global bits are 0.
- R11: Reads from an address that maps to nothing return 0. This covers a port number of 8 or above outside 0xF_, an unused port offset, and an unused global offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 384 | Event pulses, one per status bit, indexed (p*6+r)*8+b |
| we_i | input | 1 | Write strobe |
| addr_i | input | 8 | Register address: port in [7:4], offset in [3:0]; 0xF_ is global |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| irq_n_o | output | 1 | Active-low interrupt, registered |

## Verification
The assertions assume that `evt_i` carries only single-cycle pulses. They also assume that events and writes change only between clock edges, so a status bit can rise only through an event seen in the previous cycle. The bench drives every event, address and write strobe on the falling edge, and each pulse lasts exactly one cycle. Reads are taken one time unit after the address settles, away from the rising edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned OFF_W   = 4;     // per-port offset field width
  localparam int unsigned GLB_FRM = 0;     // global framer summary offset
  localparam int unsigned GLB_LIN = 1;     // global line summary offset
  localparam int unsigned GLB_TST = 2;     // global tester summary offset

  typedef struct packed {
    logic frm;
    logic lin;
    logic tst;
  } port_sum_t;
endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic         pend_o
);
  logic [W-1:0] stat_q, stat_d, en_q, en_d;
  logic         stat_ce, en_ce;

  always_comb begin
    stat_ce = clr_we_i | (|evt_i);
    // events OR in after the clear so a simultaneous set survives
    stat_d  = (stat_q & ~(clr_we_i ? wdata_i : '0)) | evt_i;
    en_ce   = en_we_i;
    en_d    = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      if (stat_ce) stat_q <= stat_d;
      if (en_ce)   en_q   <= en_d;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign pend_o = |(stat_q & en_q);
endmodule

// File: rtl/irq_port_node.sv
module irq_port_node
  import irq_agg_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned NTX = 2,
  parameter int unsigned NRX = 2,
  localparam int unsigned NSTAT = NTX + NRX + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSTAT*W-1:0] evt_i,
  input  logic               we_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [W-1:0]       wdata_i,
  output logic [NSTAT*W-1:0] stat_o,
  output logic [NSTAT*W-1:0] en_o,
  output port_sum_t          sum_o,
  output logic [W-1:0]       rdata_o
);
  localparam int unsigned OFF_TXS  = NSTAT;
  localparam int unsigned OFF_RXS  = NSTAT + 1;
  localparam int unsigned EN_BASE  = NSTAT + 2;
  localparam int unsigned IDX_LIN  = NTX + NRX;
  localparam int unsigned IDX_TST  = NTX + NRX + 1;

  logic [NSTAT-1:0] pend;
  logic [NTX-1:0]   tx_sum;
  logic [NRX-1:0]   rx_sum;

  for (genvar k = 0; k < NSTAT; k++) begin : g_bank
    irq_stat_bank #(.W(W)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i[k*W +: W]),
      .clr_we_i (we_i && (off_i == OFF_W'(k))),
      .en_we_i  (we_i && (off_i == OFF_W'(EN_BASE + k))),
      .wdata_i  (wdata_i),
      .stat_o   (stat_o[k*W +: W]),
      .en_o     (en_o[k*W +: W]),
      .pend_o   (pend[k])
    );
  end

  assign tx_sum    = pend[NTX-1:0];
  assign rx_sum    = pend[NTX +: NRX];
  assign sum_o.frm = (|tx_sum) | (|rx_sum);
  assign sum_o.lin = pend[IDX_LIN];
  assign sum_o.tst = pend[IDX_TST];

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NSTAT; k++) begin
      if (off_i == OFF_W'(k))           rdata_o = stat_o[k*W +: W];
      if (off_i == OFF_W'(EN_BASE + k)) rdata_o = en_o[k*W +: W];
    end
    if (off_i == OFF_W'(OFF_TXS)) rdata_o = W'(tx_sum);
    if (off_i == OFF_W'(OFF_RXS)) rdata_o = W'(rx_sum);
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NPORT = 8,
  parameter int unsigned W     = 8,
  parameter int unsigned NTX   = 2,
  parameter int unsigned NRX   = 2,
  parameter int unsigned AW    = 8,
  localparam int unsigned NSTAT = NTX + NRX + 2,
  localparam int unsigned PB    = NSTAT * W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT*PB-1:0] evt_i,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [W-1:0]        wdata_i,
  output logic [W-1:0]        rdata_o,
  output logic                irq_n_o
);
  localparam int unsigned HI_W = AW - OFF_W;

  logic                rst_s0, rst_sync_n;
  logic [HI_W-1:0]     hi;
  logic [OFF_W-1:0]    lo;
  logic [NPORT*PB-1:0] stat_all, en_all;
  logic [W-1:0]        port_rd [NPORT];
  logic [NPORT-1:0]    g_frm, g_lin, g_tst;
  logic                irq_n_q, irq_n_d;

  // reset synchronizer: asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_sync_n <= rst_s0;
    end
  end

  assign hi = addr_i[AW-1:OFF_W];
  assign lo = addr_i[OFF_W-1:0];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    port_sum_t sum;
    irq_port_node #(.W(W), .NTX(NTX), .NRX(NRX)) node_i (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .evt_i   (evt_i[p*PB +: PB]),
      .we_i    (we_i && (hi == HI_W'(p))),
      .off_i   (lo),
      .wdata_i (wdata_i),
      .stat_o  (stat_all[p*PB +: PB]),
      .en_o    (en_all[p*PB +: PB]),
      .sum_o   (sum),
      .rdata_o (port_rd[p])
    );
    assign g_frm[p] = sum.frm;
    assign g_lin[p] = sum.lin;
    assign g_tst[p] = sum.tst;
  end

  always_comb begin
    rdata_o = '0;
    if (hi == '1) begin
      if (lo == OFF_W'(GLB_FRM)) rdata_o = W'(g_frm);
      if (lo == OFF_W'(GLB_LIN)) rdata_o = W'(g_lin);
      if (lo == OFF_W'(GLB_TST)) rdata_o = W'(g_tst);
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (hi == HI_W'(p)) rdata_o = port_rd[p];
      end
    end
  end

  always_comb irq_n_d = ~(|{g_frm, g_lin, g_tst});

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_n_q <= 1'b1;
    else             irq_n_q <= irq_n_d;
  end

  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int unsigned NPORT = 8,
  parameter int unsigned W     = 8,
  parameter int unsigned NTX   = 2,
  parameter int unsigned NRX   = 2,
  localparam int unsigned NSTAT = NTX + NRX + 2,
  localparam int unsigned PB    = NSTAT * W
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NPORT*PB-1:0] evt,
  input logic [NPORT*PB-1:0] stat,
  input logic [NPORT*PB-1:0] en,
  input logic [NPORT-1:0]    g_frm,
  input logic [NPORT-1:0]    g_lin,
  input logic [NPORT-1:0]    g_tst,
  input logic                irq_n
);
  // R2 / R4: every pulsed bit is set one edge later, even under a clear
  assert_evt_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat & $past(evt)) == $past(evt)));

  // R2: a status bit only rises through an event
  assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~$past(stat) & ~$past(evt)) == '0);

  // R5: with nothing enabled, no summary bit can be up
  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> ({g_frm, g_lin, g_tst} == '0));

  // R10: the pin follows the summaries one edge later
  assert_irq_assert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|{g_frm, g_lin, g_tst}) |=> !irq_n);
  assert_irq_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|{g_frm, g_lin, g_tst}) |=> irq_n);

  // R7: a global line/tester bit needs an enabled set bit in that port
  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    assert_line_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      g_lin[p] |-> (|(stat[p*PB + (NTX+NRX)*W +: W] & en[p*PB + (NTX+NRX)*W +: W])));
    assert_tester_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      g_tst[p] |-> (|(stat[p*PB + (NTX+NRX+1)*W +: W] & en[p*PB + (NTX+NRX+1)*W +: W])));
  end
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NPORT (NPORT),
  .W     (W),
  .NTX   (NTX),
  .NRX   (NRX)
) chk_i (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .evt   (evt_i),
  .stat  (stat_all),
  .en    (en_all),
  .g_frm (g_frm),
  .g_lin (g_lin),
  .g_tst (g_tst),
  .irq_n (irq_n_o)
);

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;
  localparam int NPORT = 8;
  localparam int W     = 8;
  localparam int NSTAT = 6;
  localparam int NEVT  = NPORT * NSTAT * W;

  typedef struct packed {
    logic [2:0] port;
    logic [2:0] sreg;
    logic [2:0] bitn;
    logic       en;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 3'd0, 3'd0, 1'b1},
    '{3'd1, 3'd1, 3'd7, 1'b1},
    '{3'd2, 3'd2, 3'd3, 1'b1},
    '{3'd3, 3'd3, 3'd5, 1'b0},
    '{3'd4, 3'd4, 3'd1, 1'b1},
    '{3'd5, 3'd5, 3'd6, 1'b1},
    '{3'd6, 3'd4, 3'd2, 1'b0},
    '{3'd7, 3'd5, 3'd4, 1'b1}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NEVT-1:0] evt;
  logic            we;
  logic [7:0]      addr;
  logic [W-1:0]    wdata;
  logic [W-1:0]    rdata;
  logic            irq_n;
  int              tests = 0;
  int              fails = 0;

  always #4 clk = ~clk;

  irq_aggregator dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_n_o (irq_n)
  );

  function automatic logic [7:0] pa(input int p, input int off);
    return 8'((p << 4) | off);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input int p, input int r, input int b);
    @(negedge clk);
    evt[(p*NSTAT + r)*W + b] = 1'b1;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; evt = '0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    rd(pa(0, 0), d);   chk("R1 status reset", d, 0);
    rd(pa(7, 13), d);  chk("R1 enable reset", d, 0);
    rd(8'hF0, d);      chk("R1 global reset", d, 0);
    chk("R1 irq_n reset", irq_n, 1);

    // vector table walk
    foreach (VECS[i]) begin
      automatic vec_t v = VECS[i];
      automatic int p = v.port;
      automatic int r = v.sreg;
      automatic logic [7:0] bm = 8'(1 << v.bitn);
      automatic logic [7:0] ebit = v.en ? 8'hFF : 8'h00;
      wr(pa(p, 8 + r), v.en ? bm : 8'h00);
      pulse(p, r, v.bitn);
      rd(pa(p, r), d); chk("R2 latch regardless of enable", d, bm);
      chk("R10 irq_n registered delay", irq_n, 1);
      rd(pa(p, 6), d); chk("R6 tx summary", d, (r < 2) ? (8'(1 << r) & ebit) : 0);
      rd(pa(p, 7), d); chk("R6 rx summary", d, (r == 2 || r == 3) ? (8'(1 << (r-2)) & ebit) : 0);
      rd(8'hF0, d); chk("R7 global framer", d, (r < 4) ? (8'(1 << p) & ebit) : 0);
      rd(8'hF1, d); chk("R7 global line", d, (r == 4) ? (8'(1 << p) & ebit) : 0);
      rd(8'hF2, d); chk("R7 global tester", d, (r == 5) ? (8'(1 << p) & ebit) : 0);
      @(negedge clk);
      chk("R10 irq_n after one edge", irq_n, !v.en);
      wr(pa(p, r), bm);
      rd(pa(p, r), d); chk("R3 write-1 clears", d, 0);
      rd(8'hF0 + 8'(r < 4 ? 0 : r - 3), d); chk("R8 global drops live", d, 0);
      @(negedge clk);
      chk("R10 irq_n releases", irq_n, 1);
      wr(pa(p, 8 + r), 8'h00);
    end

    // R3: writing 0 bits leaves them set
    pulse(2, 0, 1); pulse(2, 0, 6);
    wr(pa(2, 0), 8'h02);
    rd(pa(2, 0), d); chk("R3 write-0 keeps bits", d, 8'h40);
    wr(pa(2, 0), 8'h00);
    rd(pa(2, 0), d); chk("R3 all-zero write no effect", d, 8'h40);

    // R4: event and clear on the same bit and cycle
    @(negedge clk);
    evt[(2*NSTAT + 0)*W + 6] = 1'b1;
    we = 1'b1; addr = pa(2, 0); wdata = 8'hFF;
    @(negedge clk);
    evt = '0; we = 1'b0;
    rd(pa(2, 0), d); chk("R4 set wins over clear", d, 8'h40);
    wr(pa(2, 0), 8'hFF);

    // R8: summary follows an enable change live
    wr(pa(5, 9), 8'h10);
    pulse(5, 1, 4);
    rd(pa(5, 6), d); chk("R8 tx summary up", d, 8'h02);
    wr(pa(5, 9), 8'h00);
    rd(pa(5, 6), d); chk("R8 tx summary drops on disable", d, 0);
    rd(pa(5, 1), d); chk("R5 disabled bit still latched", d, 8'h10);
    @(negedge clk);
    chk("R5 disabled bit no irq", irq_n, 1);

    // R9: writes to summary and global words are ignored
    wr(pa(5, 9), 8'h10);
    wr(pa(5, 6), 8'hFF);
    rd(pa(5, 6), d); chk("R9 tx summary write ignored", d, 8'h02);
    wr(pa(5, 7), 8'hFF);
    rd(pa(5, 7), d); chk("R9 rx summary write ignored", d, 0);
    wr(8'hF0, 8'h00);
    rd(8'hF0, d); chk("R9 global write ignored", d, 8'h20);
    rd(pa(5, 1), d); chk("R9 status untouched", d, 8'h10);

    // R7: two ports pending together
    wr(pa(3, 12), 8'h01);
    pulse(3, 4, 0);
    rd(8'hF1, d); chk("R7 global line port 3", d, 8'h08);
    rd(8'hF0, d); chk("R7 global framer port 5 only", d, 8'h20);

    // R11: unmapped addresses read 0
    rd(8'h80, d); chk("R11 port 8 reads zero", d, 0);
    rd(8'hF5, d); chk("R11 global hole reads zero", d, 0);
    rd(pa(5, 15), d); chk("R11 port hole reads zero", d, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule